// File: doc/BRIEF.md
# Effective Address Sequencer for an 8-bit Processor

This block works out the 16-bit effective address of an operand for an 8-bit processor with a 16-bit address space. The instruction decoder hands it a mode code, the two index registers and the program counter (pointing at the first operand byte), then pulses `start`. The block reads operand bytes, and pointer bytes where the mode needs them, one byte per cycle over a byte-wide read port. It returns the effective address, a flag telling the sequencer to add one penalty cycle, and the program counter advanced past the operand bytes.

The memory port is combinational: the block drives `mem_addr` with `mem_rd` high and samples `mem_rdata` at the next rising clock edge. A job ends with a single-cycle `done`. The results stay valid and unchanged from that cycle until the next accepted `start`. Executing the instruction itself is left to the rest of the core.

Top module: `addr_gen`

## Requirements
- R1: Mode code 0 (absolute) reads the low operand byte at `pc_in`, then the high byte at `pc_in`+1. `ea` is {high, low}, `page_pen` is 0, and `pc_out` is `pc_in`+2 modulo 65536.
- R2: Mode codes 1 and 2 add X or Y to the absolute operand modulo 65536. `page_pen` is 1 exactly when the operand low byte plus the index exceeds 255.
- R3: Mode codes 5, 6 and 7 (zero page; zero page plus X; zero page plus Y) give `ea` = {8'h00, (operand + index) mod 256}, `page_pen` 0 and `pc_out` = `pc_in`+1.
- R4: Mode code 3 uses the absolute operand as a pointer, and mode code 4 uses the absolute operand plus X (modulo 65536) as a pointer. The pointer's low byte is read at P and its high byte at (P+1) mod 65536. `ea` is the pointer value and `page_pen` is 0.
- R5: Mode codes 8, 9 and 10 read a two-byte pointer from page zero at Z, then (Z+1) mod 256. Z is the operand for codes 8 and 10, and (operand + X) mod 256 for code 9. Code 10 then adds Y modulo 65536 and flags `page_pen` when the pointer low byte plus Y exceeds 255.
- R6: Mode code 11 (relative) reads one signed byte. `ea` = (`pc_in`+1 + sign-extended byte) mod 65536. `page_pen` is the carry out of the low byte of `pc_in`+1 plus the unsigned offset byte.
- R7: `done` rises N+1 cycles after the edge that accepts `start`, where N is the number of bytes read. `done` lasts one cycle, and `mem_rd` is low whenever the block is not busy.
- R8: `start` is ignored while `busy` is high. `ea`, `page_pen` and `pc_out` hold their values from `done` until the next accepted `start`.
- R9: After reset, `busy`, `done`, `mem_rd`, `page_pen`, `ea` and `pc_out` are all 0.
- R10: Mode codes 12 to 15 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | begin a job (accepted when idle) |
| mode | input | 4 | addressing mode code |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc_in | input | 16 | address of the first operand byte |
| mem_addr | output | 16 | read address |
| mem_rd | output | 1 | read strobe |
| mem_rdata | input | 8 | read data, valid in the same cycle |
| busy | output | 1 | job in progress |
| done | output | 1 | one-cycle result strobe |
| ea | output | 16 | effective address |
| page_pen | output | 1 | page-crossing penalty flag |
| pc_out | output | 16 | program counter after the operand |

## Verification
Random jobs cover all sixteen mode codes over a hashed memory image, with random index values, program counters and memory contents. These runs separate the index choices and confirm that the penalty flag follows the low-byte carry and nothing else. Directed jobs then place bytes at the wrap points: a pointer at 0x00FF, with a decoy byte at 0x0100; an absolute pointer ending in 0xFF; an operand fetch across 0xFFFF; and indexed sums past 0xFFFF. These runs separate page-zero wrapping from full 16-bit carry propagation. Backward and forward branches show the sign extension, and a start pulse sent in the middle of a job shows that new requests are refused while the block is busy.

// File: rtl/addr_gen.sv
module addr_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [15:0] pc_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic        page_pen,
  output logic [15:0] pc_out
);
  localparam logic [3:0] M_ABS   = 4'd0;
  localparam logic [3:0] M_ABSX  = 4'd1;
  localparam logic [3:0] M_ABSY  = 4'd2;
  localparam logic [3:0] M_ABSXI = 4'd4;
  localparam logic [3:0] M_ZP    = 4'd5;
  localparam logic [3:0] M_ZPX   = 4'd6;
  localparam logic [3:0] M_ZPY   = 4'd7;
  localparam logic [3:0] M_ZPI   = 4'd8;
  localparam logic [3:0] M_ZPXI  = 4'd9;
  localparam logic [3:0] M_ZPIY  = 4'd10;
  localparam logic [3:0] M_REL   = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_OPL, S_OPH, S_PTRL, S_PTRH, S_DONE} st_t;

  st_t         st;
  logic [3:0]  md;
  logic [7:0]  xr, yr, lo_r;
  logic [15:0] pc_r, ptr_r, ea_r;
  logic        pen_r;

  logic        long_op, zp_dir, zp_ptr;
  logic [7:0]  zidx, aidx, zsum, ptr_lo_inc;
  logic [15:0] pc_nx, word, abs_sum, rel_tgt, iy_sum, ptr_hi_addr;
  logic [8:0]  abs_lo, rel_lo, iy_lo;

  assign long_op     = (md <= M_ABSXI);
  assign zp_dir      = (md >= M_ZP)  && (md <= M_ZPY);
  assign zp_ptr      = (md >= M_ZPI) && (md <= M_ZPIY);
  assign zidx        = (md == M_ZPX || md == M_ZPXI) ? xr : (md == M_ZPY) ? yr : 8'h00;
  assign aidx        = (md == M_ABSX || md == M_ABSXI) ? xr : (md == M_ABSY) ? yr : 8'h00;
  assign zsum        = mem_rdata + zidx;
  assign pc_nx       = pc_r + 16'd1;
  assign word        = {mem_rdata, lo_r};
  assign abs_lo      = {1'b0, lo_r} + {1'b0, aidx};
  assign abs_sum     = word + {8'h00, aidx};
  assign rel_lo      = {1'b0, pc_nx[7:0]} + {1'b0, mem_rdata};
  assign rel_tgt     = pc_nx + {{8{mem_rdata[7]}}, mem_rdata};
  assign iy_lo       = {1'b0, lo_r} + {1'b0, yr};
  assign iy_sum      = word + {8'h00, yr};
  assign ptr_lo_inc  = ptr_r[7:0] + 8'd1;
  assign ptr_hi_addr = zp_ptr ? {8'h00, ptr_lo_inc} : ptr_r + 16'd1;

  assign busy     = (st == S_OPL) || (st == S_OPH) || (st == S_PTRL) || (st == S_PTRH);
  assign done     = (st == S_DONE);
  assign mem_rd   = busy;
  assign ea       = ea_r;
  assign page_pen = pen_r;
  assign pc_out   = pc_r;

  always_comb begin
    case (st)
      S_PTRL:  mem_addr = ptr_r;
      S_PTRH:  mem_addr = ptr_hi_addr;
      default: mem_addr = pc_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      md    <= M_ABS;
      xr    <= 8'h00;
      yr    <= 8'h00;
      lo_r  <= 8'h00;
      pc_r  <= 16'h0000;
      ptr_r <= 16'h0000;
      ea_r  <= 16'h0000;
      pen_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            md   <= (mode > M_REL) ? M_ABS : mode;
            xr   <= idx_x;
            yr   <= idx_y;
            pc_r <= pc_in;
            st   <= S_OPL;
          end else begin
            st <= S_IDLE;
          end
        end
        S_OPL: begin
          lo_r <= mem_rdata;
          pc_r <= pc_nx;
          if (long_op) begin
            st <= S_OPH;
          end else if (zp_dir) begin
            ea_r  <= {8'h00, zsum};
            pen_r <= 1'b0;
            st    <= S_DONE;
          end else if (zp_ptr) begin
            ptr_r <= {8'h00, zsum};
            st    <= S_PTRL;
          end else begin
            ea_r  <= rel_tgt;
            pen_r <= rel_lo[8];
            st    <= S_DONE;
          end
        end
        S_OPH: begin
          pc_r <= pc_nx;
          if (md > M_ABSY) begin
            ptr_r <= abs_sum;
            st    <= S_PTRL;
          end else begin
            ea_r  <= abs_sum;
            pen_r <= abs_lo[8];
            st    <= S_DONE;
          end
        end
        S_PTRL: begin
          lo_r <= mem_rdata;
          st   <= S_PTRH;
        end
        S_PTRH: begin
          if (md == M_ZPIY) begin
            ea_r  <= iy_sum;
            pen_r <= iy_lo[8];
          end else begin
            ea_r  <= word;
            pen_r <= 1'b0;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        page_pen,
  input logic [15:0] ea,
  input logic [15:0] pc_out,
  input logic [15:0] mem_addr,
  input logic [3:0]  md,
  input logic [2:0]  st
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(ea) && $stable(pc_out) && $stable(page_pen)));

  p_zp_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md >= 4'd5 && md <= 4'd7) |-> (ea[15:8] == 8'h00));

  p_zp_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && md >= 4'd8 && md <= 4'd10) |-> (mem_addr[15:8] == 8'h00));

  p_no_pen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (md == 4'd0 || (md >= 4'd3 && md <= 4'd9))) |-> !page_pen);
endmodule

bind addr_gen addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .page_pen(page_pen), .ea(ea), .pc_out(pc_out), .mem_addr(mem_addr),
  .md(md), .st(st)
);

// File: tb/tb_addr_gen.sv
`timescale 1ns/1ps
module tb_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [7:0]  idx_x = 8'h00, idx_y = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        busy, done, page_pen;
  logic [15:0] ea, pc_out;

  int tests = 0;
  int fails = 0;
  logic [7:0]  key = 8'h5a;
  logic [15:0] ov_a [0:7];
  logic [7:0]  ov_d [0:7];
  int          ov_n = 0;
  int          ov_gen = 0;

  always #2 clk = ~clk;

  addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_x(idx_x), .idx_y(idx_y),
    .pc_in(pc_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .page_pen(page_pen), .pc_out(pc_out)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] v;
    v = (a[7:0] * 8'd37) ^ {a[11:8], a[15:12]} ^ key;
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  always @(mem_addr or key or ov_gen) mem_rdata = memf(mem_addr);

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a; ov_d[ov_n] = d; ov_n++; ov_gen++;
  endtask

  task automatic clear_ov();
    ov_n = 0; ov_gen++;
  endtask

  function automatic string tag(input logic [3:0] m);
    if (m > 4'd11) return "R10";
    case (m)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R3";
      4'd11: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic model(input logic [3:0] m_in, input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] pc, output logic [15:0] e, output logic p,
                       output logic [15:0] pco, output int n);
    logic [3:0]  m;
    logic [7:0]  b0, b1, z;
    logic [15:0] full, ptr, p1;
    logic [8:0]  lo;
    m = (m_in > 4'd11) ? 4'd0 : m_in;
    p1 = pc + 16'd1;
    b0 = memf(pc);
    b1 = memf(p1);
    full = {b1, b0};
    e = 16'h0; p = 1'b0; pco = p1; n = 1;
    if (m <= 4'd4) begin
      pco = pc + 16'd2; n = 2;
      case (m)
        4'd0: e = full;
        4'd1: begin e = full + {8'h00, x}; lo = {1'b0, b0} + {1'b0, x}; p = lo[8]; end
        4'd2: begin e = full + {8'h00, y}; lo = {1'b0, b0} + {1'b0, y}; p = lo[8]; end
        default: begin
          ptr = (m == 4'd4) ? full + {8'h00, x} : full;
          e = {memf(ptr + 16'd1), memf(ptr)}; n = 4;
        end
      endcase
    end else if (m <= 4'd7) begin
      z = (m == 4'd6) ? b0 + x : (m == 4'd7) ? b0 + y : b0;
      e = {8'h00, z};
    end else if (m <= 4'd10) begin
      z = (m == 4'd9) ? b0 + x : b0;
      full = {memf({8'h00, z + 8'd1}), memf({8'h00, z})};
      n = 3;
      if (m == 4'd10) begin
        e = full + {8'h00, y};
        lo = {1'b0, full[7:0]} + {1'b0, y}; p = lo[8];
      end else e = full;
    end else begin
      e = p1 + {{8{b0[7]}}, b0};
      lo = {1'b0, p1[7:0]} + {1'b0, b0}; p = lo[8];
    end
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                     input logic [15:0] pc, input bit spurious);
    logic [15:0] e, pco;
    logic p;
    int n, cyc;
    model(m, x, y, pc, e, p, pco, n);
    @(negedge clk);
    start = 1'b1; mode = m; idx_x = x; idx_y = y; pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      if (spurious && cyc == 2) begin
        start = 1'b1; mode = 4'd11; idx_x = ~x; idx_y = ~y; pc_in = ~pc;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R7", "latency", cyc, n + 1);
    chk(tag(m), "ea", {16'h0, ea}, {16'h0, e});
    chk(tag(m), "page_pen", {31'h0, page_pen}, {31'h0, p});
    chk(tag(m), "pc_out", {16'h0, pc_out}, {16'h0, pco});
    if (spurious) chk("R8", "ea after ignored start", {16'h0, ea}, {16'h0, e});
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [15:0] hold_ea;
    logic [15:0] hold_pc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9", "busy", {31'h0, busy}, 0);
    chk("R9", "done", {31'h0, done}, 0);
    chk("R9", "mem_rd", {31'h0, mem_rd}, 0);
    chk("R9", "ea", {16'h0, ea}, 0);
    chk("R9", "pc_out", {16'h0, pc_out}, 0);
    chk("R9", "page_pen", {31'h0, page_pen}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 operand fetch across the top of memory
    poke(16'hFFFF, 8'h34); poke(16'h0000, 8'h12);
    run(4'd0, 8'h00, 8'h00, 16'hFFFF, 0);
    clear_ov();
    // R2 index carry and 16-bit wrap
    poke(16'h1000, 8'hF0); poke(16'h1001, 8'h12);
    run(4'd1, 8'h20, 8'h00, 16'h1000, 0);
    run(4'd2, 8'h00, 8'h05, 16'h1000, 0);
    clear_ov();
    poke(16'h2000, 8'hFF); poke(16'h2001, 8'hFF);
    run(4'd1, 8'h01, 8'h00, 16'h2000, 0);
    clear_ov();
    // R3 zero-page index wraps within page zero
    poke(16'h3000, 8'hF0);
    run(4'd6, 8'h20, 8'h00, 16'h3000, 0);
    run(4'd7, 8'h00, 8'h11, 16'h3000, 0);
    clear_ov();
    // R5 pointer at 0x00FF takes high byte from 0x0000, not 0x0100
    poke(16'h4000, 8'hFF); poke(16'h00FF, 8'h34); poke(16'h0000, 8'h12); poke(16'h0100, 8'h99);
    run(4'd8, 8'h00, 8'h00, 16'h4000, 0);
    run(4'd10, 8'h00, 8'hD0, 16'h4000, 0);
    chk("R5", "wrapped pointer ea", {16'h0, ea}, 32'h1304);
    run(4'd9, 8'h00, 8'h00, 16'h4000, 0);
    clear_ov();
    // R4 absolute pointer ending in FF carries into the next page
    poke(16'h5000, 8'hFF); poke(16'h5001, 8'h12); poke(16'h12FF, 8'hCD);
    poke(16'h1300, 8'hAB); poke(16'h1200, 8'h77);
    run(4'd3, 8'h00, 8'h00, 16'h5000, 0);
    chk("R4", "pointer carry ea", {16'h0, ea}, 32'hABCD);
    run(4'd4, 8'h01, 8'h00, 16'h5000, 0);
    clear_ov();
    // R6 backward with carry, backward without, forward
    poke(16'h2010, 8'hF0); poke(16'h2000, 8'h80); poke(16'h20F0, 8'h7F);
    run(4'd11, 8'h00, 8'h00, 16'h2010, 0);
    chk("R6", "backward target", {16'h0, ea}, 32'h2001);
    run(4'd11, 8'h00, 8'h00, 16'h2000, 0);
    chk("R6", "far backward target", {16'h0, ea}, 32'h1F81);
    run(4'd11, 8'h00, 8'h00, 16'h20F0, 0);
    clear_ov();
    // R10 unused codes
    run(4'd13, 8'h44, 8'h55, 16'h6000, 0);
    // R8 start during a job is ignored; results hold afterwards
    run(4'd3, 8'h12, 8'h34, 16'h7000, 1);
    hold_ea = ea; hold_pc = pc_out;
    repeat (3) @(negedge clk);
    chk("R8", "ea hold", {16'h0, ea}, {16'h0, hold_ea});
    chk("R8", "pc_out hold", {16'h0, pc_out}, {16'h0, hold_pc});
    chk("R7", "mem_rd idle", {31'h0, mem_rd}, 0);

    for (int i = 0; i < 400; i++) begin
      key = $urandom;
      ov_gen++;
      run($urandom, $urandom, $urandom, $urandom, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule